// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block carries two-channel PCM samples over a three-wire serial link: a bit clock, a word-select line that marks which channel is on the wire, and one data line. It works either as a transmitter, turning parallel words into a serial stream, or as a receiver, turning the stream back into parallel words tagged with their channel. Parallel words enter and leave through valid/ready handshakes.

The bit clock and the word select can each be produced by the block (master) or taken from pins (slave). In master mode a programmable divider of the system clock sets the bit-clock half period. In slave mode the pins pass through two-flop synchronizers and the clock edges are found by comparing consecutive synchronized values. A polarity bit chooses which bit-clock edge launches and which captures. A second polarity bit chooses the word-select level that marks the first channel. Words are 16 bits, MSB first, with the first data bit one bit clock after the word-select change. Only matched direction settings are accepted. A mixed setting is reported and silences the pins.

Top module: `serial_audio_port`

## Requirements
- R1: After reset with all configuration inputs 0, the block is a slave: sck_oe=0, ws_oe=0, sd_oe=0, cfg_err=0, tx_ready=1 and rx_valid=0.
- R2: With cfg_clk_dir=1 and cfg_ws_dir=1 the block is master: sck_oe=1, ws_oe=1, and sck_out holds each level for cfg_half_div system clocks, where any value below 4 acts as 4.
- R3: In master mode ws_out changes once every 16 bit-clock periods.
- R4: With cfg_clk_inv=0, sd_out and a master-driven ws_out change within 2 system clocks after a falling sck edge, and sd_in and a slave ws_in are sampled on the rising edge. With cfg_clk_inv=1 the two edges swap.
- R5: With cfg_ws_inv=0 the word-select line is low for the first channel (rx_chan=0) and high for the second (rx_chan=1). cfg_ws_inv=1 inverts the levels.
- R6: In transmit mode (cfg_tx_mode=1) words accepted on tx_valid&&tx_ready go out in acceptance order, MSB first, starting one bit clock after a word-select change. In master mode the first accepted word goes to the first channel.
- R7: If no word is waiting when a channel slot starts, the transmitter sends 16 zero bits in that slot.
- R8: In receive mode (cfg_tx_mode=0) each completed word appears on rx_data with rx_chan naming its channel. rx_valid stays 1 until rx_ready is 1. A newer word replaces an unread one.
- R9: When cfg_clk_dir differs from cfg_ws_dir, cfg_err is 1 from the next cycle, and sck_oe, ws_oe, sd_oe and sd_out are all 0. A matched setting clears cfg_err on the next cycle.
- R10: sd_oe is 1 only in transmit mode with a legal setting, and sd_out is 0 whenever sd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_clk_dir | input | 1 | 1: block drives the bit clock |
| cfg_ws_dir | input | 1 | 1: block drives word select |
| cfg_clk_inv | input | 1 | 0: launch on falling, capture on rising edge; 1: swapped |
| cfg_ws_inv | input | 1 | 0: word select low marks the first channel; 1: high |
| cfg_tx_mode | input | 1 | 1: transmit, 0: receive |
| cfg_half_div | input | 8 | Bit-clock half period in system clocks (minimum 4) |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit holding slot is empty |
| rx_data | output | 16 | Received word |
| rx_chan | output | 1 | Channel of rx_data (0 first, 1 second) |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_ready | input | 1 | Consumer takes rx_data |
| sck_in | input | 1 | Bit clock from pin (slave) |
| sck_out | output | 1 | Bit clock to pin (master) |
| sck_oe | output | 1 | Bit-clock pin output enable |
| ws_in | input | 1 | Word select from pin (slave) |
| ws_out | output | 1 | Word select to pin (master) |
| ws_oe | output | 1 | Word-select pin output enable |
| sd_in | input | 1 | Serial data from pin |
| sd_out | output | 1 | Serial data to pin |
| sd_oe | output | 1 | Data pin output enable |
| cfg_err | output | 1 | Mixed direction setting present |

## Verification
The hardest case to reach from the ports is the slot boundary. There, word select flips on the same launch edge that carries the old word's LSB, and the next word must begin exactly one bit later. A wrong polarity or an off-by-one shows up only as a rotated word. The bench decodes the master stream from sck_out, ws_out and sd_out at the selected capture edge. It also drives a slave stream whose word-select change sits on each LSB. Both polarity pairs are run, so a word comes back intact only if the framing and the edge choice are both right.

// File: rtl/sap_pkg.sv
// Shared types for the serial audio port.
// Assumes: one mode value per cycle, decided from the direction bits.
package sap_pkg;
    typedef enum logic [1:0] {
        MODE_SLAVE  = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_BAD    = 2'd2
    } sap_mode_e;

    localparam int SAP_MIN_HALF = 4;
endpackage

// File: rtl/sap_master_timer.sv
// Master timing: divides the system clock into the bit clock and counts
// launch edges to toggle the channel every WORD_W bits.
// Assumes: launch is a one-cycle strobe derived from sck_lvl; while run is 0
// the timer rests with the clock low and the channel on the second slot, so
// the first launch edge opens the first channel.
module sap_master_timer #(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    input  logic             launch,
    output logic             sck_lvl,
    output logic             chan
);
    import sap_pkg::*;

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] MIN_D = DIV_W'(SAP_MIN_HALF);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] eff_half;
    logic [BIT_W-1:0] bit_cnt;

    // clamp the requested half period to the supported minimum
    always_comb eff_half = (half_div < MIN_D) ? MIN_D : half_div;

    // half-period counter and bit-clock level
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            sck_lvl <= 1'b0;
        end else if (div_cnt == eff_half - 1'b1) begin
            div_cnt <= '0;
            sck_lvl <= ~sck_lvl;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // bit position and channel, advanced on launch edges
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            bit_cnt <= LAST_BIT;
            chan    <= 1'b1;
        end else if (launch) begin
            if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                chan    <= ~chan;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R3
    ws_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && chan != $past(chan)) |-> $past(launch));
endmodule

// File: rtl/sap_edge_select.sv
// Edge selection: synchronizes the pins, picks the bit-clock source and
// turns its edges into launch and capture strobes per the polarity bit.
// Assumes: the system clock runs at least eight times the bit clock in slave
// mode; data and word select share the clock's synchronizer depth.
module sap_edge_select #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic clk_inv,
    input  logic m_sck,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic launch,
    output logic capture,
    output logic ws_s,
    output logic sd_s
);
    logic [SYNC-1:0] sck_sy, ws_sy, sd_sy;
    logic lvl, prev_lvl, rise, fall;

    // two-flop style synchronizers for the three pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy <= '0;
            ws_sy  <= '0;
            sd_sy  <= '0;
        end else begin
            sck_sy <= {sck_sy[SYNC-2:0], sck_in};
            ws_sy  <= {ws_sy[SYNC-2:0], ws_in};
            sd_sy  <= {sd_sy[SYNC-2:0], sd_in};
        end
    end

    // previous bit-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= lvl;
    end

    // source choice, edge detection and polarity mapping
    always_comb begin
        lvl     = is_master ? m_sck : sck_sy[SYNC-1];
        rise    = lvl & ~prev_lvl;
        fall    = ~lvl & prev_lvl;
        capture = clk_inv ? fall : rise;
        launch  = clk_inv ? rise : fall;
        ws_s    = ws_sy[SYNC-1];
        sd_s    = sd_sy[SYNC-1];
    end

    // R4
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);
endmodule

// File: rtl/sap_shifter.sv
// Serial shifter: frames words on word-select changes seen at capture edges,
// shifts transmit data out at launch edges and receive data in at capture
// edges, and runs the parallel handshakes.
// Assumes: launch and capture never coincide; chan_now is the channel
// currently on the word-select line (0 first, 1 second).
module sap_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tx_mode,
    input  logic              launch,
    input  logic              capture,
    input  logic              chan_now,
    input  logic              sd_s,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_chan,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              sd_q
);
    logic              seen;
    logic              load_pend;
    logic              hold_v;
    logic [WORD_W-1:0] hold;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] next_word;
    logic              slot_edge, accept, consume, emit;

    // event decode for this cycle
    always_comb begin
        slot_edge = capture && (chan_now != seen);
        accept    = tx_valid && !hold_v;
        consume   = launch && load_pend && tx_mode && hold_v;
        emit      = slot_edge && !tx_mode;
        next_word = hold_v ? hold : '0;
        tx_ready  = !hold_v;
    end

    // transmit holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold   <= '0;
        end else begin
            if (consume) hold_v <= 1'b0;
            if (accept) begin
                hold_v <= 1'b1;
                hold   <= tx_data;
            end
        end
    end

    // slot tracking: note word-select changes, arm the next launch
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            seen      <= 1'b1;
            load_pend <= 1'b0;
        end else if (capture) begin
            seen <= chan_now;
            if (chan_now != seen) load_pend <= 1'b1;
        end else if (launch) begin
            load_pend <= 1'b0;
        end
    end

    // transmit shift register and data output bit
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx_sh <= '0;
            sd_q  <= 1'b0;
        end else if (launch && tx_mode) begin
            if (load_pend) begin
                sd_q  <= next_word[WORD_W-1];
                tx_sh <= next_word << 1;
            end else begin
                sd_q  <= tx_sh[WORD_W-1];
                tx_sh <= tx_sh << 1;
            end
        end
    end

    // receive shift register
    always_ff @(posedge clk) begin
        if (!rst_n || !active) rx_sh <= '0;
        else if (capture && !tx_mode) rx_sh <= {rx_sh[WORD_W-2:0], sd_s};
    end

    // receive output register and valid/ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_chan  <= 1'b0;
            rx_valid <= 1'b0;
        end else if (emit) begin
            rx_data  <= {rx_sh[WORD_W-2:0], sd_s};
            rx_chan  <= seen;
            rx_valid <= 1'b1;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    // R6
    tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R4
    sd_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && sd_q != $past(sd_q)) |-> $past(launch));
endmodule

// File: rtl/serial_audio_port.sv
// Stereo serial audio port top: decodes the direction bits into a mode,
// connects master timing, edge selection and the shifter, and gates the
// pin outputs.
// Assumes: configuration inputs are quasi-static; a mode change is followed
// by a reset or tolerated losing the current slot.
module serial_audio_port #(
    parameter int WORD_W      = 16,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_clk_dir,
    input  logic              cfg_ws_dir,
    input  logic              cfg_clk_inv,
    input  logic              cfg_ws_inv,
    input  logic              cfg_tx_mode,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_chan,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              ws_in,
    output logic              ws_out,
    output logic              ws_oe,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              cfg_err
);
    import sap_pkg::*;

    sap_mode_e mode_q, mode_n;
    logic is_master, active;
    logic m_sck, m_chan;
    logic launch, capture, ws_s, sd_s, sd_q;
    logic chan_now;

    // next mode from the direction pair
    always_comb begin
        if (cfg_clk_dir != cfg_ws_dir) mode_n = MODE_BAD;
        else if (cfg_clk_dir)          mode_n = MODE_MASTER;
        else                           mode_n = MODE_SLAVE;
    end

    // registered mode
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SLAVE;
        else        mode_q <= mode_n;
    end

    // mode flags, channel source and pin gating
    always_comb begin
        is_master = (mode_q == MODE_MASTER);
        active    = (mode_q != MODE_BAD);
        cfg_err   = (mode_q == MODE_BAD);
        chan_now  = is_master ? m_chan : (ws_s ^ cfg_ws_inv);
        sck_oe    = is_master;
        ws_oe     = is_master;
        sck_out   = is_master & m_sck;
        ws_out    = is_master & (m_chan ^ cfg_ws_inv);
        sd_oe     = active & cfg_tx_mode;
        sd_out    = sd_oe & sd_q;
    end

    sap_master_timer #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (is_master),
        .half_div (cfg_half_div),
        .launch   (launch),
        .sck_lvl  (m_sck),
        .chan     (m_chan)
    );

    sap_edge_select #(.SYNC(SYNC_STAGES)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .clk_inv   (cfg_clk_inv),
        .m_sck     (m_sck),
        .sck_in    (sck_in),
        .ws_in     (ws_in),
        .sd_in     (sd_in),
        .launch    (launch),
        .capture   (capture),
        .ws_s      (ws_s),
        .sd_s      (sd_s)
    );

    sap_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tx_mode  (cfg_tx_mode),
        .launch   (launch),
        .capture  (capture),
        .chan_now (chan_now),
        .sd_s     (sd_s),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_chan  (rx_chan),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .sd_q     (sd_q)
    );

    // R9
    bad_dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_dir != cfg_ws_dir) |=> (cfg_err && !sck_oe && !ws_oe && !sd_oe && !sd_out));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_dir == cfg_ws_dir) |=> !cfg_err);
endmodule

// File: tb/sim_serial_audio_port.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_serial_audio_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_clk_dir = 0, cfg_ws_dir = 0, cfg_clk_inv = 0, cfg_ws_inv = 0, cfg_tx_mode = 0;
    logic [7:0]  cfg_half_div = 8'd4;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 0, rx_ready = 1;
    logic        sck_in = 0, ws_in = 0, sd_in = 0;
    logic        tx_ready, rx_chan, rx_valid, sck_out, sck_oe, ws_out, ws_oe, sd_out, sd_oe, cfg_err;
    logic [15:0] rx_data;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    logic [15:0] sw [6];
    logic        sc [6];

    always #2 clk = ~clk;

    serial_audio_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_clk_dir(cfg_clk_dir), .cfg_ws_dir(cfg_ws_dir),
        .cfg_clk_inv(cfg_clk_inv), .cfg_ws_inv(cfg_ws_inv), .cfg_tx_mode(cfg_tx_mode),
        .cfg_half_div(cfg_half_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .ws_in(ws_in), .ws_out(ws_out),
        .ws_oe(ws_oe), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        cfg_clk_dir = 0; cfg_ws_dir = 0; cfg_clk_inv = 0; cfg_ws_inv = 0; cfg_tx_mode = 0;
        do_reset();
        @(negedge clk);
        chk(!sck_oe && !ws_oe && !sd_oe, "R1", "output enables", {sck_oe, ws_oe, sd_oe}, 0);
        chk(!cfg_err, "R1", "cfg_err", cfg_err, 0);
        chk(tx_ready && !rx_valid, "R1", "tx_ready/rx_valid", {tx_ready, rx_valid}, 2'b10);
    endtask

    // R2 R3 R4 R5 R6 R7 R10: master transmit, decoded from the pins
    task automatic t_master_tx(input bit cinv, input bit winv, input int div, input int half);
        logic [15:0] wv [4];
        logic [15:0] gw [8];
        logic        gc [8];
        int nchg = 0, nbits = 0, toggles = 0, since_tog = 0, since_l = 99;
        int bad_half = 0, bad_edge = 0, bad_slot = 0, cyc = 0;
        logic ps, pw, pd, wprev;
        logic [15:0] sh = '0;
        wv[0] = 16'hA53C; wv[1] = 16'h0F81; wv[2] = 16'h8001; wv[3] = 16'h7FFE;
        cfg_clk_dir = 1; cfg_ws_dir = 1; cfg_clk_inv = cinv; cfg_ws_inv = winv;
        cfg_tx_mode = 1; cfg_half_div = 8'(div);
        do_reset();
        @(negedge clk); @(negedge clk);
        chk(sck_oe && ws_oe, "R2", "master enables", {sck_oe, ws_oe}, 2'b11);
        chk(sd_oe, "R10", "sd_oe in transmit", sd_oe, 1);
        ps = sck_out; pw = ws_out; pd = sd_out; wprev = 1'b1 ^ winv;
        fork
            begin
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    while (!tx_ready) @(negedge clk);
                    tx_data = wv[i]; tx_valid = 1'b1;
                    @(negedge clk);
                    tx_valid = 1'b0;
                end
            end
            begin
                while (nchg < 7 && cyc < 4000) begin
                    @(negedge clk);
                    cyc++; since_tog++; since_l++;
                    if (sck_out != ps) begin
                        toggles++;
                        if (toggles > 1 && since_tog != half) bad_half++;
                        since_tog = 0;
                        if (sck_out == cinv) since_l = 0;
                        else begin
                            sh = {sh[14:0], sd_out};
                            nbits++;
                            if (ws_out != wprev) begin
                                nchg++;
                                if (nchg >= 2) begin
                                    if (nbits != 16) bad_slot++;
                                    gw[nchg-2] = sh;
                                    gc[nchg-2] = wprev ^ winv;
                                end
                                nbits = 0;
                                wprev = ws_out;
                            end
                        end
                    end
                    if ((sd_out != pd || ws_out != pw) && since_l > 2) bad_edge++;
                    ps = sck_out; pw = ws_out; pd = sd_out;
                end
            end
        join
        chk(nchg == 7, "R6", "slots seen", nchg, 7);
        chk(bad_half == 0, "R2", "half periods off", bad_half, 0);
        chk(bad_slot == 0, "R3", "slots not 16 bits", bad_slot, 0);
        chk(bad_edge == 0, "R4", "changes away from launch edge", bad_edge, 0);
        for (int i = 0; i < 6; i++) begin
            if (i < 4) chk(gw[i] == wv[i], "R6", "tx word", gw[i], wv[i]);
            else       chk(gw[i] == 16'h0, "R7", "underrun word", gw[i], 0);
            chk(gc[i] == 1'(i % 2), "R5", "tx channel", gc[i], i % 2);
        end
    endtask

    // drives sw/sc as a slave stream, half period 8 system clocks
    task automatic drive_stream(input int n, input bit cinv, input bit winv);
        for (int j = 0; j < n; j++) begin
            for (int b = 15; b >= 0; b--) begin
                @(negedge clk);
                sck_in = cinv;
                ws_in  = ((b == 0 && j < n - 1) ? sc[j+1] : sc[j]) ^ winv;
                sd_in  = sw[j][b];
                repeat (8) @(negedge clk);
                sck_in = ~cinv;
                repeat (7) @(negedge clk);
            end
        end
    endtask

    // R4 R5 R8 R10: slave receive
    task automatic t_slave_rx(input bit cinv, input bit winv);
        logic [15:0] gw [4];
        logic        gc [4];
        int got = 0;
        sw[0] = 16'h1234; sc[0] = 1; sw[1] = 16'hC3A5; sc[1] = 0;
        sw[2] = 16'h5A0F; sc[2] = 1; sw[3] = 16'h8E71; sc[3] = 0;
        sw[4] = 16'hFFFF; sc[4] = 1;
        cfg_clk_dir = 0; cfg_ws_dir = 0; cfg_clk_inv = cinv; cfg_ws_inv = winv; cfg_tx_mode = 0;
        sck_in = cinv; ws_in = 1'b1 ^ winv; sd_in = 0; rx_ready = 1;
        do_reset();
        @(negedge clk);
        chk(!sck_oe && !ws_oe && !sd_oe && !sd_out, "R10", "slave receive pins quiet",
            {sck_oe, ws_oe, sd_oe, sd_out}, 0);
        fork
            drive_stream(5, cinv, winv);
            begin
                repeat (1400) begin
                    @(negedge clk);
                    if (rx_valid && got < 4) begin
                        gw[got] = rx_data; gc[got] = rx_chan; got++;
                    end
                end
            end
        join
        chk(got == 4, "R8", "rx word count", got, 4);
        for (int i = 0; i < 4; i++) begin
            if (i < got) begin
                chk(gw[i] == sw[i], "R4", "rx word (capture edge)", gw[i], sw[i]);
                chk(gc[i] == sc[i], "R5", "rx channel", gc[i], sc[i]);
            end
        end
    endtask

    // R8: rx_valid held without rx_ready, newer word replaces
    task automatic t_rx_hold();
        sw[0] = 16'h0BAD; sc[0] = 1; sw[1] = 16'h600D; sc[1] = 0; sw[2] = 16'h0; sc[2] = 1;
        cfg_clk_dir = 0; cfg_ws_dir = 0; cfg_clk_inv = 0; cfg_ws_inv = 0; cfg_tx_mode = 0;
        sck_in = 0; ws_in = 1; sd_in = 0; rx_ready = 0;
        do_reset();
        drive_stream(3, 1'b0, 1'b0);
        @(negedge clk);
        chk(rx_valid, "R8", "rx_valid held", rx_valid, 1);
        chk(rx_data == 16'h600D && rx_chan == 1'b0, "R8", "latest word kept",
            {rx_chan, rx_data}, {1'b0, 16'h600D});
        rx_ready = 1;
        @(negedge clk);
        chk(!rx_valid, "R8", "rx_valid after ready", rx_valid, 0);
    endtask

    // R9: mixed directions
    task automatic t_prohibited();
        cfg_clk_dir = 1; cfg_ws_dir = 0; cfg_tx_mode = 1; cfg_half_div = 8'd4;
        do_reset();
        repeat (20) @(negedge clk);
        chk(cfg_err, "R9", "err clock-only master", cfg_err, 1);
        chk(!sck_oe && !ws_oe && !sd_oe && !sd_out, "R9", "pins quiet",
            {sck_oe, ws_oe, sd_oe, sd_out}, 0);
        cfg_clk_dir = 0; cfg_ws_dir = 1;
        repeat (20) @(negedge clk);
        chk(cfg_err && !ws_oe && !sd_out, "R9", "err ws-only master",
            {cfg_err, ws_oe, sd_out}, 3'b100);
        cfg_clk_dir = 1;
        @(negedge clk);
        chk(!cfg_err && sck_oe && ws_oe, "R9", "legal master clears err",
            {cfg_err, sck_oe, ws_oe}, 3'b011);
    endtask

    initial begin
        t_reset();
        t_master_tx(1'b0, 1'b0, 4, 4);
        t_master_tx(1'b1, 1'b1, 2, 4);
        t_master_tx(1'b0, 1'b1, 6, 6);
        t_slave_rx(1'b0, 1'b0);
        t_slave_rx(1'b1, 1'b1);
        t_rx_hold();
        t_prohibited();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule